// File: doc/BRIEF.md
# Write-Only Two-Wire Setpoint Slave for a Sink-Current DAC

This block is the serial control port of a current-sink driver. The port holds one 8-bit setpoint that feeds a DAC. A bus master writes the setpoint over the standard two-wire I2C bus. The block receives the bus clock and data lines and passes both through synchronizers clocked by the system clock. It recognises its own 7-bit write address, of which two low bits are set by pins, and acknowledges that address. Every data byte after the address is acknowledged and loaded directly into the setpoint. The port has no readback and no internal sub-address. A read-direction address gets no answer.

The code on `code_o` sets the target sink current at code × 500 µA. Code 0 switches the sink off, and `drive_en_o` reports that state. The setpoint is a plain level output, so no back-pressure or handshake applies to it; only the bus controls when it changes.

A clear input for power-up and supply faults forces the code to zero. The active-low sleep input holds every register inactive and releases the bus line. The system clock must run at least eight times faster than the bus clock.

Top module: `sink_dac_i2c_port`

## Requirements
- R1: A falling SDA while SCL is high is a start condition and makes the port wait for an address byte. A rising SDA while SCL is high is a stop condition and returns the port to idle.
- R2: The first byte after a start is sampled MSB first on SCL rising edges. It is acknowledged only when its upper five bits are 00011, bits 2:1 equal `addr_sel_i`, and bit 0 is 0 (write). The acknowledged byte values are therefore 0x18, 0x1A, 0x1C and 0x1E.
- R3: An address byte that does not match, or one with bit 0 set to 1 (read), gets no acknowledge. Data bytes that follow it, up to the next start, neither drive SDA nor change the code.
- R4: The acknowledge pull-down on SDA starts only after SCL falls at the end of the eighth bit. It covers the ninth clock and is released after the ninth clock falls.
- R5: Each data byte in a transfer, received MSB first, replaces the code and is acknowledged. Any number of bytes may follow one address.
- R6: `drive_en_o` is 1 exactly when `code_o` is nonzero.
- R7: `clear_i` high sets the code to 0 on the next clock edge and takes priority over a byte being written at the same time.
- R8: While `sleep_n_i` is low, the code reads 0, the drive is off, SDA is never pulled, and bus traffic is ignored.
- R9: A start or stop inside a byte or an acknowledge abandons the byte without changing the code. After a start, the next byte is taken as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| clear_i | input | 1 | Supply-fault clear of the setpoint |
| sleep_n_i | input | 1 | Active-low sleep; holds all logic inactive |
| addr_sel_i | input | 2 | Selectable low bits of the 7-bit address |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| code_o | output | 8 | DAC setpoint code |
| drive_en_o | output | 1 | Sink drive enabled (code nonzero) |

## Verification
The address decoder is tried with all 256 first-byte values while one select setting is applied. This separates the four fixed bits, the two selected bits and the direction bit, since each mismatch must produce a missing acknowledge. Every select setting then gets one matching write. A single transfer carrying all 256 data codes shows that each byte replaces the previous one, including the 0-to-nonzero edges of the drive enable. Separate patterns cover aborts by a start or a stop inside a byte, a data byte sent after a read address, and a clear or a sleep applied over a nonzero code. These patterns show that no partial byte, rejected address, fault or sleep period leaves a code behind.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK
  } link_state_t;
endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stg <= '1;
    else if (hold) stg <= '1;
    else           stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdp_bus_events.sv
module sdp_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (hold) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/sdp_byte_engine.sv
module sdp_byte_engine
  import sdp_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         SEL_W     = 2,
  parameter logic [6:0] ADDR_BASE = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              scl_fall,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  link_state_t       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_byte;
  logic              addr_ok;
  logic              byte_done;

  assign next_byte = {shreg[DATA_W-2:0], sda_s};
  assign byte_done = scl_rise && (bit_cnt == LAST_BIT);
  assign addr_ok   = (next_byte[0] == 1'b0) &&
                     (next_byte[7:SEL_W+1] == ADDR_BASE[6:SEL_W]) &&
                     (next_byte[SEL_W:1] == addr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
    end else if (hold) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
              bit_cnt <= '0;
              if (state == ST_DATA) state <= ST_DATA_ACK;
              else                  state <= addr_ok ? ST_ADDR_ACK : ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            if (!sda_pull) begin
              sda_pull <= 1'b1;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_DATA;
              bit_cnt  <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en   = !hold && !start_ev && !stop_ev && (state == ST_DATA) && byte_done;
  assign wr_data = next_byte;
endmodule

// File: rtl/sink_dac_i2c_port.sv
module sink_dac_i2c_port #(
  parameter int         DATA_W      = 8,
  parameter int         SEL_W       = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sleep_n_i,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] code_o,
  output logic              drive_en_o
);
  logic              hold;
  logic [1:0]        bus_s;
  logic              start_ev, stop_ev, scl_rise, scl_fall;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] setpoint;

  assign hold = !sleep_n_i;

  sdp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .d({scl_i, sda_i}), .q(bus_s)
  );

  sdp_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  sdp_byte_engine #(.DATA_W(DATA_W), .SEL_W(SEL_W), .ADDR_BASE(ADDR_BASE)) u_engine (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .addr_sel(addr_sel_i), .sda_s(bus_s[0]),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               setpoint <= '0;
    else if (clear_i || hold) setpoint <= '0;
    else if (wr_en)           setpoint <= wr_data;
  end

  assign code_o     = setpoint;
  assign drive_en_o = sleep_n_i && (setpoint != '0);
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              sleep_n_i,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [DATA_W-1:0] code_o,
  input logic              drive_en_o
);
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (code_o == '0));

  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |-> (!sda_pull_o && !drive_en_o));

  a_r8_sleep_code: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |=> (code_o == '0));

  a_r4_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  a_r5_write_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(code_o) && $past(sleep_n_i) && !$past(clear_i)) |-> !sda_pull_o);

  a_r6_off_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) |-> !drive_en_o);
endmodule

bind sink_dac_i2c_port sdp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sleep_n_i(sleep_n_i),
  .scl_i(scl_i), .sda_pull_o(sda_pull_o), .code_o(code_o), .drive_en_o(drive_en_o)
);

// File: tb/sink_dac_i2c_port_tb.sv
module sink_dac_i2c_port_tb;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       sleep_n = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_line;
  logic       pull;
  logic [7:0] code;
  logic       en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_drv & ~pull;

  sink_dac_i2c_port u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .sleep_n_i(sleep_n),
    .addr_sel_i(sel), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .code_o(code), .drive_en_o(en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; waitq(Q);
    scl = 1'b1;     waitq(Q);
    sda_drv = 1'b0; waitq(Q);
    scl = 1'b0;     waitq(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; waitq(Q);
    scl = 1'b1;     waitq(Q);
    sda_drv = 1'b1; waitq(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_drv = b; waitq(Q);
    scl = 1'b1;  waitq(2 * Q);
    scl = 1'b0;  waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; waitq(Q);
    scl = 1'b1;     waitq(Q);
    acked = !sda_line;
    waitq(Q);
    scl = 1'b0;     waitq(Q);
  endtask

  task automatic write_code(input logic [7:0] addr, input logic [7:0] val);
    bit a;
    bus_start();
    send_byte(addr, a);
    send_byte(val, a);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] exp_addr;
    waitq(4);
    chk(code == 8'h00 && !en && !pull, "R7 reset state", {en, code}, 0);
    rst_n = 1'b1;
    waitq(4);

    // R2/R3: every first-byte value with select = 2
    sel = 2'd2;
    for (int a = 0; a < 256; a++) begin
      bus_start();
      send_byte(8'(a), ack);
      bus_stop();
      chk(ack == (a == 8'h1C), (a == 8'h1C) ? "R2 address ack" : "R3 address reject",
          int'(ack), int'(a == 8'h1C));
    end

    // R2: each select setting matches its own write address
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      exp_addr = 8'h18 | 8'(s << 1);
      bus_start();
      send_byte(exp_addr, ack);
      bus_stop();
      chk(ack, "R2 select match", int'(ack), 1);
    end

    // R5/R6/R4: all codes in one transfer
    sel = 2'd1;
    bus_start();
    send_byte(8'h1A, ack);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'((v * 37 + 11) & 8'hFF);
      send_byte(d, ack);
      chk(ack, "R5 data ack", int'(ack), 1);
      chk(code == d, "R5 code update", code, d);
      chk(en == (d != 0), "R6 drive enable", en, int'(d != 0));
      chk(!pull, "R4 pull released", pull, 0);
    end
    bus_stop();

    // R3: data after a read address ignored
    write_code(8'h1A, 8'h5A);
    bus_start();
    send_byte(8'h1B, ack);
    chk(!ack, "R3 read not acked", int'(ack), 0);
    send_byte(8'hC3, ack);
    bus_stop();
    chk(!ack && code == 8'h5A, "R3 data ignored", code, 8'h5A);

    // R9/R1: repeated start mid-byte
    bus_start();
    send_byte(8'h1A, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    chk(code == 8'h5A, "R9 partial byte by start", code, 8'h5A);
    bus_start();
    send_byte(8'h1A, ack);
    chk(ack, "R1 restart address ack", int'(ack), 1);
    send_byte(8'h81, ack);
    bus_stop();
    chk(code == 8'h81, "R1 write after restart", code, 8'h81);

    // R9: stop mid-byte
    bus_start();
    send_byte(8'h1A, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    scl = 1'b0; bus_stop();
    waitq(Q);
    chk(code == 8'h81, "R9 partial byte by stop", code, 8'h81);
    bus_start();
    send_byte(8'h1A, ack);
    send_byte(8'h42, ack);
    bus_stop();
    chk(code == 8'h42, "R1 write after stop", code, 8'h42);

    // R7: clear
    clear = 1'b1; waitq(1); clear = 1'b0; waitq(1);
    chk(code == 8'h00 && !en, "R7 clear", {en, code}, 0);

    // R8: sleep
    write_code(8'h1A, 8'h33);
    chk(code == 8'h33, "R8 pre-sleep write", code, 8'h33);
    sleep_n = 1'b0; waitq(2);
    chk(code == 8'h00 && !en, "R8 sleep output off", {en, code}, 0);
    bus_start();
    send_byte(8'h1A, ack);
    chk(!ack, "R8 no ack in sleep", int'(ack), 0);
    send_byte(8'h77, ack);
    bus_stop();
    chk(code == 8'h00 && !pull, "R8 traffic ignored", code, 0);
    sleep_n = 1'b1; waitq(4);
    write_code(8'h1A, 8'h09);
    chk(code == 8'h09 && en, "R8 wake write", code, 8'h09);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule